// File: doc/BRIEF.md
# History-Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The counter it consults is chosen by two things together: a row picked by the low-order bits of the branch address, and a column picked by a short global register holding the outcomes of the most recently resolved branches, wherever in the program they sit. Each counter is a 2-bit saturating counter. Its upper bit is the guess. Because a counter must move through two steps to change its upper bit, a single surprise does not flip the guess.

A fetch stage presents a branch address on the lookup port and gets the guess back combinationally in the same cycle. The current global history is visible on `curHist`, so the caller can carry it down the pipeline with the branch. When the branch resolves, the caller presents the address, that carried history and the real outcome on the update port. The block then trains the single counter the lookup used and shifts the outcome into the global history. Entries carry no address tag, so branches whose low index bits match share counters.

Top module: `hist_branch_pred`

## Requirements
- R1: After reset every counter is weakly not-taken (value 1), so every lookup predicts not-taken, and `curHist` reads 0.
- R2: `lookupTaken` is the upper bit of the counter at row `lookupPc[3:0]` and column `curHist`, and it is valid in the same cycle as `lookupPc`.
- R3: An update with `updTaken`=1 raises the selected counter by one, stopping at 3.
- R4: An update with `updTaken`=0 lowers the selected counter by one, stopping at 0.
- R5: An update changes only the counter at row `updPc[3:0]` and column `updHist`; all other counters keep their values, and nothing changes while `updValid` is 0.
- R6: One edge after an update, `curHist` becomes its old value shifted left by one with `updTaken` entering bit 0 and the oldest bit dropped; without an update it holds.
- R7: Address bits above bit 3 have no effect: addresses that agree in bits 3:0 read and train the same counters.
- R8: A lookup in the same cycle as an update to the entry it reads returns the counter value from before that update.
- R9: The update picks its column from `updHist`, not from the live `curHist`.
- R10: From a strongly taken counter, one not-taken outcome leaves the guess at taken; a second consecutive one turns it to not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | Address of the branch being predicted |
| lookupTaken | output | 1 | Guess: 1 taken, 0 not taken |
| curHist | output | 2 | Global outcome history, newest outcome in bit 0 |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updHist | input | 2 | History that was current when that branch was predicted |
| updTaken | input | 1 | Actual outcome of the resolved branch |

## Verification
The guess is combinational, so the bench samples it 1 ns after changing `lookupPc`, with no clock edge in between. Counter and history changes take effect at the first rising edge after `updValid` is driven; the bench drives inputs 1 ns after an edge and reads `curHist` and the new guesses 1 ns after the next edge. The pre-update value of R8 is sampled before that edge, while the update is still being driven. Because only the live column can be read at the lookup port, the bench steers the history through updates to a scratch row and tracks all 64 counters in its own model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int IDX_BITS  = 4;
  localparam int HIST_BITS = 2;
  localparam int CTR_W     = 2;
  localparam int ENT_BITS  = IDX_BITS + HIST_BITS;
  localparam int ENTRIES   = 1 << ENT_BITS;

  // strobes from control to datapath
  typedef struct packed {
    logic                ctrWe;
    logic [ENT_BITS-1:0] ctrIdx;
    logic                ctrUp;
    logic                histShift;
    logic                histIn;
  } strobe_t;

  function automatic logic [ENT_BITS-1:0] entryIdx(
    input logic [IDX_BITS-1:0]  row,
    input logic [HIST_BITS-1:0] hist);
    return {row, hist};
  endfunction
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic                 updValid,
  input  logic [IDX_BITS-1:0]  updRow,
  input  logic [HIST_BITS-1:0] updHist,
  input  logic                 updTaken,
  output strobe_t              stb
);
  always_comb begin
    stb           = '0;
    stb.ctrIdx    = entryIdx(updRow, updHist);
    stb.ctrUp     = updTaken;
    stb.histIn    = updTaken;
    if (updValid) begin
      stb.ctrWe     = 1'b1;
      stb.histShift = 1'b1;
    end
  end
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [IDX_BITS-1:0]  lookupRow,
  output logic                 lookupTaken,
  output logic [HIST_BITS-1:0] curHist
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [ENTRIES*CTR_W-1:0] ctrFlat;
  logic [HIST_BITS-1:0]     histReg;
  logic [ENT_BITS-1:0]      readIdx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [CTR_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= WEAK_NT;
      end else if (stb.ctrWe && (stb.ctrIdx == ENT_BITS'(e))) begin
        if (stb.ctrUp) begin
          if (cnt != CTR_MAX) cnt <= cnt + 1'b1;
        end else begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
      end
    end
    assign ctrFlat[e*CTR_W +: CTR_W] = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              histReg <= '0;
    else if (stb.histShift) histReg <= HIST_BITS'({histReg, stb.histIn});
  end

  assign readIdx     = entryIdx(lookupRow, histReg);
  assign lookupTaken = ctrFlat[readIdx*CTR_W + (CTR_W - 1)];
  assign curHist     = histReg;
endmodule

// File: rtl/hist_branch_pred.sv
module hist_branch_pred
  import bp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      lookupPc,
  output logic                 lookupTaken,
  output logic [HIST_BITS-1:0] curHist,
  input  logic                 updValid,
  input  logic [PC_W-1:0]      updPc,
  input  logic [HIST_BITS-1:0] updHist,
  input  logic                 updTaken
);
  strobe_t             stb;
  logic [IDX_BITS-1:0] lookupRow;
  logic [IDX_BITS-1:0] updRow;
  logic                unusedPcBits;

  assign lookupRow    = lookupPc[IDX_BITS-1:0];
  assign updRow       = updPc[IDX_BITS-1:0];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_BITS], updPc[PC_W-1:IDX_BITS]};

  bp_ctrl u_ctrl (
    .updValid (updValid),
    .updRow   (updRow),
    .updHist  (updHist),
    .updTaken (updTaken),
    .stb      (stb)
  );

  bp_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .lookupRow   (lookupRow),
    .lookupTaken (lookupTaken),
    .curHist     (curHist)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker
  import bp_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 updValid,
  input logic                 updTaken,
  input logic [IDX_BITS-1:0]  lookupRow,
  input logic                 lookupTaken,
  input logic [HIST_BITS-1:0] curHist,
  input logic                 stbWe
);
  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> curHist == HIST_BITS'({$past(curHist), $past(updTaken)}));

  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(curHist));

  p_pred_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(lookupRow) && $stable(curHist) && !$past(updValid)) |-> $stable(lookupTaken));

  p_idle_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !stbWe);
endmodule

bind hist_branch_pred bp_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .updValid    (updValid),
  .updTaken    (updTaken),
  .lookupRow   (lookupRow),
  .lookupTaken (lookupTaken),
  .curHist     (curHist),
  .stbWe       (stb.ctrWe)
);

// File: tb/hist_branch_pred_bench.sv
module hist_branch_pred_bench;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        lookupTaken;
  logic [1:0]  curHist;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updHist = '0;
  logic        updTaken = 1'b0;

  int total = 0;
  int bad = 0;
  int mdl[64];
  int mh = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CYC/2) clk = ~clk;

  hist_branch_pred u_hist_branch_pred (
    .clk (clk), .rstN (rstN), .lookupPc (lookupPc), .lookupTaken (lookupTaken),
    .curHist (curHist), .updValid (updValid), .updPc (updPc), .updHist (updHist),
    .updTaken (updTaken)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mdlTrain(input logic [31:0] pc, input int h, input int t);
    int idx;
    idx = int'(pc[3:0]) * 4 + h;
    if (t != 0) begin if (mdl[idx] < 3) mdl[idx]++; end
    else begin if (mdl[idx] > 0) mdl[idx]--; end
    mh = ((mh << 1) | t) & 3;
  endtask

  task automatic upd(input logic [31:0] pc, input int h, input int t);
    updPc = pc; updHist = 2'(h); updTaken = t[0]; updValid = 1'b1;
    @(posedge clk); #1;
    updValid = 1'b0;
    mdlTrain(pc, h, t);
    chk("R6 history shift", int'(curHist), mh);
  endtask

  task automatic setHist(input int h);
    upd(32'h0000_000F, mh, (h >> 1) & 1);
    upd(32'h0000_000F, mh, h & 1);
  endtask

  task automatic expectPc(input string req, input logic [31:0] pc, input int exp);
    lookupPc = pc; #1;
    chk(req, int'(lookupTaken), exp);
  endtask

  task automatic sweepRows(input string req, input logic [27:0] high);
    for (int r = 0; r < 16; r++) begin
      lookupPc = {high, 4'(r)}; #1;
      chk(req, int'(lookupTaken), (mdl[r*4 + mh] >= 2) ? 1 : 0);
    end
  endtask

  initial begin
    #(CYC * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 history cleared", int'(curHist), 0);
    sweepRows("R1 reset predicts not-taken", 28'h0);

    // R3 / R10 / R4 on row 5, column 2
    setHist(2);
    expectPc("R1 row5 untouched", 32'h5, 0);
    upd(32'h5, 2, 1);
    setHist(2);
    expectPc("R3 one taken flips weak NT", 32'h5, 1);
    repeat (3) upd(32'h5, 2, 1);
    upd(32'h5, 2, 0);
    setHist(2);
    expectPc("R10 one NT from strong keeps taken", 32'h5, 1);
    chk("R3 saturated at 3 then one step", mdl[5*4+2], 2);
    upd(32'h5, 2, 0);
    setHist(2);
    expectPc("R10 second NT turns not-taken", 32'h5, 0);
    repeat (3) upd(32'h5, 2, 0);
    upd(32'h5, 2, 1);
    setHist(2);
    expectPc("R4 saturated at 0, one taken stays NT", 32'h5, 0);
    upd(32'h5, 2, 1);
    setHist(2);
    expectPc("R4 second taken from floor flips", 32'h5, 1);

    // R9 / R5: column comes from updHist
    upd(32'h7, 1, 1);
    upd(32'h7, 1, 1);
    for (int h = 0; h < 4; h++) begin
      setHist(h);
      expectPc("R9 R5 only updHist column trained", 32'h7, (h == 1) ? 1 : 0);
    end

    // R7: high address bits ignored
    setHist(1);
    expectPc("R7 lookup alias", 32'hABCD_0007, 1);
    upd(32'hFFF0_0003, 0, 1);
    upd(32'hFFF0_0003, 0, 1);
    setHist(0);
    expectPc("R7 update alias", 32'h0000_0003, 1);
    expectPc("R7 lookup alias other high bits", 32'h1230_0003, 1);

    // R8: same-cycle lookup sees pre-update value
    setHist(3);
    lookupPc = 32'h9;
    updPc = 32'h9; updHist = 2'd3; updTaken = 1'b1; updValid = 1'b1;
    #1;
    chk("R8 pre-update value", int'(lookupTaken), 0);
    @(posedge clk); #1;
    updValid = 1'b0;
    mdlTrain(32'h9, 3, 1);
    chk("R6 history shift", int'(curHist), mh);
    setHist(3);
    expectPc("R8 update landed after edge", 32'h9, 1);

    // R2 / R5: pseudo-random sweep against model
    for (int n = 0; n < 300; n++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      upd(seed, int'(seed[9:8]), int'(seed[12]));
      sweepRows("R2 R5 sweep vs model", seed[31:4]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule